// File: doc/BRIEF.md
# GPIO Interrupt Channel Multiplexer

The block takes a wide vector of GPIO pad inputs and drives eight interrupt channel lines towards a parent interrupt controller. Each channel picks one pad through an 8-bit index held in a pad-select register. It then conditions the picked signal so that the parent only ever sees active-high requests. A level request appears as a high level. A rising or falling edge, or any transition, appears as a single-clock high pulse.

Software sets the block up through a small register window. A write strobe, a 4-bit byte address and a 32-bit data word make up a full-word write. A separate read-data output returns the register at the current address, combinationally. A trigger register holds three bits per channel: edge mode, low polarity and both-edge. Both-edge overrides the other two. Low polarity inverts the pad before the mode logic, which turns low-level and falling-edge requests into active-high outputs. A filter-select register stores a 4-bit code per channel. It is readable, but no logic uses it.

All pads pass through a two-flop synchroniser. When software changes the source or mode of a channel, that channel's edge history is discarded, so the reconfiguration cannot produce a pulse of its own. Register accesses are plain control pins with no handshake, and the channel outputs are plain level lines. Nothing in the block can stall, so it needs no valid/ready flow control.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset every register reads 0 and every channel output is 0.
- R2: Registers decode at byte offsets 0x0 (trigger), 0x4 (pad select, channels 0-3), 0x8 (pad select, channels 4-7) and 0xC (filter select). Trigger bits 31:24 read 0. Any other address reads 0, and a write to it changes nothing.
- R3: Channel n takes its 8-bit pad index from bits (n mod 4)*8+7 down to (n mod 4)*8 of register 0x4 when n<4, and of register 0x8 otherwise.
- R4: With trigger bits n, 8+n and 16+n all clear (level, high), channel n follows its selected pad. The output changes on the third rising clock edge after the pad changes.
- R5: With trigger bit 16+n set and bit 8+n clear, the selected pad is inverted before the mode logic. Level-low mode therefore gives a high output while the pad is low.
- R6: With trigger bit n set and bit 16+n clear, a rising pad edge gives exactly one high output cycle, on the third clock edge after the change. A falling edge gives none.
- R7: With trigger bits n and 16+n set, a falling pad edge gives one high cycle and a rising edge gives none.
- R8: With trigger bit 8+n set, every pad transition gives one high cycle, whatever bits n and 16+n hold.
- R9: A pad index at or beyond the number of implemented pads selects a constant 0. With low polarity that gives a constant high level.
- R10: A write that changes a channel's pad index or its trigger bits leaves that channel's output low for the cycles that follow, even when the new source or polarity turns the conditioned signal from low to high.
- R11: Register 0xC stores and returns a full 32-bit word (4 bits per channel, channel n at bit 4n). Writing it does not change any channel output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Full-word register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pad_in | input | NUM_PADS | Asynchronous GPIO pad inputs |
| irq_out | output | 8 | Active-high interrupt line per channel |

## Verification
The assertions check four things on every cycle. They confirm that single-edge mode never produces a pulse longer than one cycle and that a configuration change always forces the affected channel low in the next cycle. They also confirm that unmapped addresses and the unused trigger bits read 0, and that the outputs are quiet straight after reset. Other behaviour is only visible through the bench's scenarios. This covers the exact three-cycle latency from pad to output, the inversion, which edges give a pulse in each mode, the override by both-edge, and out-of-range pad indices. It also covers register field placement and readback, and the absence of a spurious pulse when a source or polarity change turns the conditioned signal from low to high.

// File: rtl/gim_pkg.sv
package gim_pkg;
  localparam int unsigned CH_NUM = 8;
  localparam int unsigned SEL_W  = 8;
  localparam int unsigned FLT_W  = 4;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned PAD_SPAN = 1 << SEL_W;

  localparam logic [ADDR_W-1:0] OFS_TRIG   = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_SEL_LO = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_SEL_HI = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_FILT   = 4'hC;

  // Trigger register field bases (channel n adds n)
  localparam int unsigned TRIG_EDGE_B = 0;
  localparam int unsigned TRIG_BOTH_B = 8;
  localparam int unsigned TRIG_LOW_B  = 16;

  typedef struct packed {
    logic             edge_en;
    logic             both_en;
    logic             low_pol;
    logic [SEL_W-1:0] sel;
  } ch_cfg_t;
endpackage

// File: rtl/gim_sync.sv
module gim_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gim_regs.sv
module gim_regs
  import gim_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output ch_cfg_t [CH_NUM-1:0]           cfg_o,
  output logic [CH_NUM-1:0]              cfg_chg_o
);
  logic [CH_NUM-1:0] edge_q, both_q, low_q;
  logic [CH_NUM-1:0][SEL_W-1:0] sel_all;
  logic [CH_NUM-1:0][FLT_W-1:0] flt_all;

  logic hit_trig, hit_lo, hit_hi, hit_flt;
  assign hit_trig = wr && (addr == OFS_TRIG);
  assign hit_lo   = wr && (addr == OFS_SEL_LO);
  assign hit_hi   = wr && (addr == OFS_SEL_HI);
  assign hit_flt  = wr && (addr == OFS_FILT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      both_q <= '0;
      low_q  <= '0;
    end else if (hit_trig) begin
      edge_q <= wdata[TRIG_EDGE_B +: CH_NUM];
      both_q <= wdata[TRIG_BOTH_B +: CH_NUM];
      low_q  <= wdata[TRIG_LOW_B  +: CH_NUM];
    end
  end

  for (genvar n = 0; n < CH_NUM; n++) begin : g_ch
    localparam int unsigned FB  = (n % 4) * SEL_W;
    localparam int unsigned FFB = n * FLT_W;
    logic             my_hit;
    logic [SEL_W-1:0] sel_q;
    logic [FLT_W-1:0] flt_q;
    logic             trig_diff, sel_diff;

    if (n < 4) begin : g_lo
      assign my_hit = hit_lo;
    end else begin : g_hi
      assign my_hit = hit_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q <= '0;
      end else if (my_hit) begin
        sel_q <= wdata[FB +: SEL_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flt_q <= '0;
      end else if (hit_flt) begin
        flt_q <= wdata[FFB +: FLT_W];
      end
    end

    assign trig_diff = {wdata[TRIG_EDGE_B+n], wdata[TRIG_BOTH_B+n], wdata[TRIG_LOW_B+n]}
                       != {edge_q[n], both_q[n], low_q[n]};
    assign sel_diff  = wdata[FB +: SEL_W] != sel_q;
    assign cfg_chg_o[n] = (hit_trig && trig_diff) || (my_hit && sel_diff);

    assign sel_all[n]       = sel_q;
    assign flt_all[n]       = flt_q;
    assign cfg_o[n].edge_en = edge_q[n];
    assign cfg_o[n].both_en = both_q[n];
    assign cfg_o[n].low_pol = low_q[n];
    assign cfg_o[n].sel     = sel_q;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_TRIG: begin
        rdata[TRIG_EDGE_B +: CH_NUM] = edge_q;
        rdata[TRIG_BOTH_B +: CH_NUM] = both_q;
        rdata[TRIG_LOW_B  +: CH_NUM] = low_q;
      end
      OFS_SEL_LO: begin
        for (int k = 0; k < 4; k++) rdata[k*SEL_W +: SEL_W] = sel_all[k];
      end
      OFS_SEL_HI: begin
        for (int k = 0; k < 4; k++) rdata[k*SEL_W +: SEL_W] = sel_all[k+4];
      end
      OFS_FILT: begin
        for (int k = 0; k < CH_NUM; k++) rdata[k*FLT_W +: FLT_W] = flt_all[k];
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gim_channel.sv
module gim_channel
  import gim_pkg::*;
#(
  parameter int unsigned NUM_PADS = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pads_s,
  input  ch_cfg_t             cfg,
  input  logic                cfg_chg,
  output logic                irq_o
);
  logic [PAD_SPAN-1:0] padded;
  logic raw, cond, det, edge_mode;
  logic prev_q, armed_q, irq_q;

  // Indices past the implemented pads land on zero-extended bits
  assign padded    = PAD_SPAN'(pads_s);
  assign raw       = padded[cfg.sel];
  assign cond      = cfg.both_en ? raw : (raw ^ cfg.low_pol);
  assign edge_mode = cfg.edge_en | cfg.both_en;
  assign det       = cfg.both_en ? (cond ^ prev_q) : (cond & ~prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (cfg_chg) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      prev_q  <= cond;
      armed_q <= 1'b1;
      irq_q   <= edge_mode ? (armed_q & det) : cond;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
  import gim_pkg::*;
#(
  parameter int unsigned NUM_PADS    = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [3:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [7:0]          irq_out
);
  ch_cfg_t [CH_NUM-1:0] cfg_w;
  logic [CH_NUM-1:0]   cfg_chg_w;
  logic [CH_NUM-1:0]   edge_en_w, both_en_w;
  logic [NUM_PADS-1:0] pads_s;

  gim_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .cfg_o     (cfg_w),
    .cfg_chg_o (cfg_chg_w)
  );

  gim_sync #(.W(NUM_PADS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pads_s)
  );

  for (genvar n = 0; n < CH_NUM; n++) begin : g_chan
    assign edge_en_w[n] = cfg_w[n].edge_en;
    assign both_en_w[n] = cfg_w[n].both_en;
    gim_channel #(.NUM_PADS(NUM_PADS)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .pads_s  (pads_s),
      .cfg     (cfg_w[n]),
      .cfg_chg (cfg_chg_w[n]),
      .irq_o   (irq_out[n])
    );
  end
endmodule

// File: rtl/gim_checker.sv
module gim_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [3:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic [7:0]  irq_out,
  input logic [7:0]  edge_en,
  input logic [7:0]  both_en,
  input logic [7:0]  cfg_chg
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_out == 8'h00));

  p_trig_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 4'h0) |-> (reg_rdata[31:24] == 8'h00));

  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_addr inside {4'h0, 4'h4, 4'h8, 4'hC}) |-> (reg_rdata == 32'h0));

  for (genvar n = 0; n < 8; n++) begin : g_prop
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_en[n] && !both_en[n] && !reg_wr && irq_out[n]) |=> !irq_out[n]);

    p_cfg_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg[n] |=> !irq_out[n]);
  end
endmodule

bind gpio_irq_mux gim_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out),
  .edge_en   (edge_en_w),
  .both_en   (both_en_w),
  .cfg_chg   (cfg_chg_w)
);

// File: tb/tb_gpio_irq_mux.sv
module tb_gpio_irq_mux;
  localparam int NP = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_addr = 4'h0;
  logic [31:0]   reg_wdata = 32'h0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [7:0]    irq_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  int    q_at[$];
  int    q_ch[$];
  bit    q_val[$];
  string q_tag[$];

  gpio_irq_mux #(.NUM_PADS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in), .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  // Monitor: compares scoreboard items in their due cycle
  initial begin
    forever begin
      @(posedge clk);
      cyc = cyc + 1;
      #2;
      for (int k = q_at.size() - 1; k >= 0; k--) begin
        if (q_at[k] <= cyc) begin
          n_chk++;
          if (q_at[k] < cyc || irq_out[q_ch[k]] !== q_val[k]) begin
            n_fail++;
            $display("FAIL %s: ch%0d at cycle %0d got %b expected %b",
                     q_tag[k], q_ch[k], q_at[k], irq_out[q_ch[k]], q_val[k]);
          end
          q_at.delete(k); q_ch.delete(k); q_val.delete(k); q_tag.delete(k);
        end
      end
    end
  end

  task automatic expect_at(int offs, int ch, bit v, string tag);
    q_at.push_back(cyc + offs);
    q_ch.push_back(ch);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    n_chk++;
    if (reg_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: read 0x%h got 0x%h expected 0x%h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1: reset state
    rd_chk(4'h0, 32'h0, "R1 trig");
    rd_chk(4'h4, 32'h0, "R1 sel_lo");
    rd_chk(4'h8, 32'h0, "R1 sel_hi");
    rd_chk(4'hC, 32'h0, "R1 filt");
    n_chk++;
    if (irq_out !== 8'h00) begin
      n_fail++;
      $display("FAIL R1: irq_out got 0x%h expected 0x00", irq_out);
    end

    // R2: decode and unused bits
    wr(4'h0, 32'hFFFF_FFFF);
    rd_chk(4'h0, 32'h00FF_FFFF, "R2 trig mask");
    wr(4'h2, 32'h1234_5678);
    rd_chk(4'h2, 32'h0, "R2 unmapped read");
    rd_chk(4'h0, 32'h00FF_FFFF, "R2 unmapped write ignored");
    wr(4'h0, 32'h0);
    rd_chk(4'h0, 32'h0, "R2 trig clear");

    // R3/R4: field placement and level-high following
    wr(4'h4, 32'h0000_0005);
    wr(4'h8, 32'h0000_4D00);
    rd_chk(4'h4, 32'h0000_0005, "R3 sel_lo");
    rd_chk(4'h8, 32'h0000_4D00, "R3 sel_hi");
    tick(4);
    pad_in[5] = 1'b1;
    expect_at(2, 0, 1'b0, "R4 latency early");
    expect_at(3, 0, 1'b1, "R4 level high");
    expect_at(3, 5, 1'b0, "R3 other channel");
    tick(5);
    pad_in[77] = 1'b1;
    expect_at(3, 5, 1'b1, "R3 ch5 pad77");
    expect_at(3, 0, 1'b1, "R4 level hold");
    tick(5);

    // R5: level low
    wr(4'h0, 32'h0001_0000);
    expect_at(2, 0, 1'b0, "R5 inverted high pad");
    tick(3);
    pad_in[5] = 1'b0;
    expect_at(3, 0, 1'b1, "R5 level low");
    tick(5);

    // R6: rising edge
    wr(4'h4, 32'h0000_0A05);
    wr(4'h0, 32'h0001_0002);
    tick(4);
    pad_in[10] = 1'b1;
    expect_at(2, 1, 1'b0, "R6 early");
    expect_at(3, 1, 1'b1, "R6 pulse");
    expect_at(4, 1, 1'b0, "R6 one cycle");
    expect_at(5, 1, 1'b0, "R6 stays low");
    tick(6);
    pad_in[10] = 1'b0;
    expect_at(3, 1, 1'b0, "R6 no pulse on fall");
    expect_at(4, 1, 1'b0, "R6 no pulse on fall");
    tick(6);

    // R7: falling edge
    wr(4'h4, 32'h0014_0A05);
    wr(4'h0, 32'h0005_0006);
    expect_at(1, 2, 1'b0, "R7 no pulse at setup");
    tick(4);
    pad_in[20] = 1'b1;
    expect_at(3, 2, 1'b0, "R7 no pulse on rise");
    expect_at(4, 2, 1'b0, "R7 no pulse on rise");
    tick(6);
    pad_in[20] = 1'b0;
    expect_at(3, 2, 1'b1, "R7 pulse on fall");
    expect_at(4, 2, 1'b0, "R7 one cycle");
    tick(6);

    // R8: both edges override
    wr(4'h4, 32'h1E14_0A05);
    wr(4'h0, 32'h000D_080E);
    tick(4);
    pad_in[30] = 1'b1;
    expect_at(3, 3, 1'b1, "R8 rise pulse");
    expect_at(4, 3, 1'b0, "R8 rise one cycle");
    tick(6);
    pad_in[30] = 1'b0;
    expect_at(3, 3, 1'b1, "R8 fall pulse");
    expect_at(4, 3, 1'b0, "R8 fall one cycle");
    tick(6);

    // R9: out-of-range pad index
    wr(4'h8, 32'h0000_4DC8);
    tick(3);
    expect_at(1, 4, 1'b0, "R9 index 200 reads 0");
    tick(2);
    wr(4'h0, 32'h001D_080E);
    expect_at(3, 4, 1'b1, "R9 index 200 inverted");
    tick(5);

    // R10: source change and polarity change give no pulse
    pad_in[11] = 1'b1;
    tick(5);
    wr(4'h4, 32'h1E14_0B05);
    for (int k = 1; k <= 4; k++) expect_at(k, 1, 1'b0, "R10 source change");
    tick(6);
    wr(4'h0, 32'h001D_084E);
    tick(4);
    wr(4'h0, 32'h005D_084E);
    for (int k = 1; k <= 4; k++) expect_at(k, 6, 1'b0, "R10 polarity change");
    tick(6);

    // R11: filter register
    wr(4'hC, 32'hDEAD_BEEF);
    for (int k = 1; k <= 3; k++) begin
      expect_at(k, 0, 1'b1, "R11 ch0 unaffected");
      expect_at(k, 4, 1'b1, "R11 ch4 unaffected");
    end
    rd_chk(4'hC, 32'hDEAD_BEEF, "R11 filt readback");
    rd_chk(4'h0, 32'h005D_084E, "R11 trig intact");
    rd_chk(4'h4, 32'h1E14_0B05, "R11 sel intact");

    tick(8);
    while (q_at.size() != 0) tick(1);
    finish_run();
  end
endmodule